// File: doc/BRIEF.md
# Toggle-Flop Accumulating Adder

This block holds a running total in a register of W bits. Each clock edge with the add enable high adds an operand word to the stored total. The adder is a ripple chain of majority-gate carries. The carry into bit 0 is tied to zero.

No bit of the register is reloaded with a sum bit. Each storage bit is a toggle flip-flop. Bit i inverts when the enable is high and operand bit i differs from the carry that arrives at that bit. Otherwise it keeps its value. A synchronous clear, active low, empties the register and wins over the enable. With the enable low the total stays where it is.

The carry out of the top bit is a combinational output. It comes from the present total and the present operand, so it shows whether the next enabled add will wrap around.

Top module: `toggle_accum`

## Requirements
- R1: When `clear_n` is 0 at a rising edge of `clk`, `acc` is all zeros after that edge, whatever `add_en` and `operand` are.
- R2: When `clear_n` is 1 and `add_en` is 0 at a rising edge, `acc` keeps its value across that edge, whatever `operand` is.
- R3: When `clear_n` is 1 and `add_en` is 1 at a rising edge, `acc` becomes (`acc` + `operand`) modulo 2^W after that edge.
- R4: `carry_out` always equals bit W of the (W+1)-bit sum of the present `acc` and `operand`, with a carry-in of zero.
- R5: On an enabled add, `acc` bit 0 inverts exactly when `operand` bit 0 is 1, because the carry into bit 0 is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low; takes priority over add_en |
| add_en | input | 1 | Add enable; 1 adds operand into the total at the edge |
| operand | input | W | Word added to the total |
| acc | output | W | Present accumulated total |
| carry_out | output | 1 | Carry out of the top bit for acc + operand |

## Verification
The model is run with operand patterns that each expose a different fault:
- All zeros shows whether any bit toggles without reason.
- All ones, added to a non-zero total, drives a carry through every bit. This exposes a break in the chain or a wrong majority term.
- A single set bit and alternating bit patterns separate each bit's toggle condition from its neighbours' carries.
- Sums just above and just below 2^W test the wrap and `carry_out`.

Clears are issued with the enable high, and holds with a non-zero operand. Either case shows at once whether the priority or the gating of the toggle is wrong.

// File: rtl/tacc_pkg.sv
package tacc_pkg;

    // Default register width.
    localparam int unsigned TACC_DEF_W = 8;

    // Per-bit result of one adder slice: toggle request and carry onward.
    typedef struct packed {
        logic tog;
        logic cout;
    } tacc_slice_t;

    // Majority of three inputs: the carry produced by a full adder.
    function automatic logic tacc_maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // A bit's stored value flips when the addend bit and the incoming
    // carry disagree; the carry onward is the majority of all three.
    function automatic tacc_slice_t tacc_slice(input logic x, input logic y, input logic cin);
        tacc_slice_t s;
        s.tog  = y ^ cin;
        s.cout = tacc_maj3(x, y, cin);
        return s;
    endfunction

endpackage

// File: rtl/tacc_carry_chain.sv
module tacc_carry_chain
    import tacc_pkg::*;
#(
    parameter int unsigned W = TACC_DEF_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] tog,
    output logic         cout
);

    localparam int unsigned NC = W + 1;

    logic [NC-1:0] carry;
    tacc_slice_t   slice [W];

    // Carry into the least significant bit is tied low.
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        always_comb begin
            slice[i] = tacc_slice(x[i], y[i], carry[i]);
        end
        assign tog[i]       = slice[i].tog;
        assign carry[i + 1] = slice[i].cout;
    end

    assign cout = carry[W];

endmodule

// File: rtl/tacc_tff.sv
module tacc_tff (
    input  logic clk,
    input  logic clr_n,
    input  logic t,
    output logic q
);

    // Synchronous clear wins; otherwise the stored bit is XORed with t.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            q <= q ^ t;
        end
    end

endmodule

// File: rtl/toggle_accum.sv
module toggle_accum
    import tacc_pkg::*;
#(
    parameter int unsigned W = TACC_DEF_W
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         add_en,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc,
    output logic         carry_out
);

    logic [W-1:0] tog_raw;
    logic [W-1:0] tog_gated;
    logic [W-1:0] state_q;

    tacc_carry_chain #(.W(W)) u_chain (
        .x    (state_q),
        .y    (operand),
        .tog  (tog_raw),
        .cout (carry_out)
    );

    // Toggle input of each bit: enable AND (operand bit XOR carry in).
    assign tog_gated = tog_raw & {W{add_en}};

    for (genvar i = 0; i < W; i++) begin : g_bit
        tacc_tff u_ff (
            .clk   (clk),
            .clr_n (clear_n),
            .t     (tog_gated[i]),
            .q     (state_q[i])
        );
    end

    assign acc = state_q;

endmodule

// File: rtl/tacc_checker.sv
module tacc_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         clear_n,
    input logic         add_en,
    input logic [W-1:0] operand,
    input logic [W-1:0] acc,
    input logic         carry_out
);

    logic         clr_prev = 1'b0;
    logic [W:0]   ext_sum;

    assign ext_sum = {1'b0, acc} + {1'b0, operand};

    always_ff @(posedge clk) begin
        clr_prev <= !clear_n;
    end

    // R1
    always @(posedge clk) begin
        if (clr_prev) begin
            clear_zero_chk: assert (acc == '0)
                else $error("clear_zero_chk: acc=%h", acc);
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (!add_en) |=> $stable(acc));

    // R3
    sum_chk: assert property (@(posedge clk) disable iff (!clear_n)
        add_en |=> (acc == W'($past(acc) + $past(operand))));

    // R4
    carry_chk: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out == ext_sum[W]);

    // R5
    lsb_toggle_chk: assert property (@(posedge clk) disable iff (!clear_n)
        add_en |=> (acc[0] == ($past(acc[0]) ^ $past(operand[0]))));

endmodule

bind toggle_accum tacc_checker #(.W(W)) u_tacc_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .add_en    (add_en),
    .operand   (operand),
    .acc       (acc),
    .carry_out (carry_out)
);

// File: tb/tb_toggle_accum.sv
`timescale 1ns/1ps
module tb_toggle_accum;

    localparam int unsigned W = 8;
    localparam int unsigned MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         add_en = 1'b0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    int model  = 0;   // reference total, kept in 0 .. 2^W-1
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    toggle_accum #(.W(W)) dut (
        .clk       (clk),
        .clear_n   (clear_n),
        .add_en    (add_en),
        .operand   (operand),
        .acc       (acc),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // One clock: drive at the falling edge, check the combinational carry,
    // update the model, then check the register just after the rising edge.
    task automatic step(input bit clr, input bit en, input int y, input string req);
        @(negedge clk);
        clear_n = !clr;
        add_en  = en;
        operand = W'(y);
        #1;
        check("R4 carry_out", int'(carry_out), ((model + (y & MASK)) >> W) & 1);
        if (clr)       model = 0;
        else if (en)   model = (model + (y & MASK)) & MASK;
        @(posedge clk);
        #1;
        check(req, int'(acc), model);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        // R1: clear from power-up
        step(1, 0, 0, "R1 reset");
        step(1, 0, 0, "R1 reset");
        // R5: carry-in zero; adding 1 flips bit 0 only
        step(0, 1, 1, "R5 lsb toggle");
        step(0, 1, 0, "R3 add zero");
        step(0, 1, 8'hFF, "R3 all ones ripple");
        step(0, 0, 8'hA5, "R2 hold");
        step(0, 0, 8'hFF, "R2 hold");
        step(0, 1, 8'h55, "R3 alternating");
        step(0, 1, 8'hAA, "R3 alternating");
        step(0, 1, 8'h80, "R3 single msb");
        // R1: clear wins over enable
        step(1, 1, 8'h3C, "R1 clear priority");
        // wrap just past 2^W and to exactly 2^W
        step(0, 1, 8'hF0, "R3 load");
        step(0, 1, 8'h10, "R3 wrap to zero");
        step(0, 1, 8'hFE, "R3 load");
        step(0, 1, 8'h03, "R3 wrap past");
        step(0, 1, 8'h7F, "R3 below wrap");
        // R5: even operand leaves bit 0
        step(0, 1, 8'h02, "R5 lsb steady");
        for (int i = 0; i < W; i++) begin
            step(0, 1, 1 << i, "R3 single bit");
        end
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom;
            step((r & 32'h3F) == 0, (r & 32'h300) != 0, (r >> 12) & MASK, "R3 random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule